// File: doc/BRIEF.md
# Cache-Line Request Coalescing Table

This block sits between the lane-level memory pipeline and the memory side. An instruction arrives as a set of lane requests. Each request has an address, and a mask selects the active lanes. The block groups the active lanes whose addresses fall in the same cache line into one coalesced entry. It creates at most one such entry per cycle, so at most one instruction is coalesced per cycle. The input is held until every line of the instruction has an entry, and only then is it accepted. Lanes from two different instructions never share an entry, even when they target the same line.

Entries live in a small table that works like an MSHR. Each entry holds its line, the sequence number of its instruction, the access kind, the mask of merged lanes and the cycle in which it was issued. Several entries may hold the same line. Among those, only the oldest may be issued or answered, so same-line traffic is served strictly in age order. A response names a line and retires the oldest issued entry for that line. One cycle later the block reports the entry's instruction, its lane mask and the latency measured from issue. The number of live entries is visible at all times, and no new entry is created once it reaches the configured limit.

Top module: `coal_table`

## Requirements
- R1: After reset, `outstanding` is 0, `mem_req_valid` is 0 and `cpl_valid` is 0.
- R2: The line of a lane is its address shifted right by log2(LINE_BYTES) bits (4 with the defaults). All pending lanes of one instruction that share the line of the lowest-numbered pending lane form one entry, and that entry's line is the one carried by `mem_req_line`.
- R3: An instruction that touches N distinct lines takes N cycles to absorb, one entry per cycle. `in_ready` is high in the cycle its last entry is created. An instruction with an all-zero lane mask is accepted in the cycle it is presented.
- R4: Lanes of different instructions are never merged. Two instructions that each touch the same line create two entries.
- R5: A new entry is created only while `outstanding` is below MAX_OUT. Otherwise `in_ready` stays low and the instruction is held until a retirement makes room.
- R6: When several entries hold the same line, only the oldest is offered on the memory side. The next one is offered only after the oldest has retired, and this holds even if the next one was created in the same cycle as that retirement.
- R7: `mem_req_valid` is high whenever some entry that is not yet issued is at the head of its line. An entry counts as issued at a clock edge where both `mem_req_valid` and `mem_req_ready` are high.
- R8: A response whose `mem_rsp_line` matches an issued head entry retires that entry. In the next cycle `cpl_valid` is high, with the entry's `cpl_seq`, `cpl_mask` and `cpl_write`.
- R9: A response that matches no issued head entry is ignored. This covers an unknown line and a line whose entry is not yet issued. No completion follows and `outstanding` does not change.
- R10: `cpl_latency` equals the number of clock edges from the issue edge to the response edge.
- R11: `outstanding` rises by one per created entry and falls by one per retirement. When both happen at the same edge it stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction's lane requests are presented |
| in_seq | input | SEQ_W | Instruction sequence number |
| in_write | input | 1 | 1 = write access, 0 = read access |
| in_mask | input | LANES | Active lanes |
| in_addr | input | LANES*ADDR_W | Lane addresses, lane l at bits [l*ADDR_W +: ADDR_W] |
| in_ready | output | 1 | Instruction fully absorbed this cycle |
| mem_req_valid | output | 1 | An entry is offered to the memory side |
| mem_req_ready | input | 1 | Memory side takes the offered entry |
| mem_req_line | output | ADDR_W-log2(LINE_BYTES) | Line of the offered entry |
| mem_req_write | output | 1 | Access kind of the offered entry |
| mem_rsp_valid | input | 1 | A response arrives |
| mem_rsp_line | input | ADDR_W-log2(LINE_BYTES) | Line being answered |
| cpl_valid | output | 1 | A completion is reported |
| cpl_seq | output | SEQ_W | Instruction of the retired entry |
| cpl_mask | output | LANES | Lanes served by the retired entry |
| cpl_write | output | 1 | Access kind of the retired entry |
| cpl_latency | output | TIME_W | Cycles from issue to response |
| outstanding | output | clog2(MAX_OUT+1) | Number of live entries |

## Verification
The two events that can share a cycle are a response that retires the head entry of a line and the creation of a new entry for that same line. The bench drives both at the same edge. It then checks three results in the next cycle: the completion is for the old entry, the count is unchanged, and the new entry is offered at once because it is already head of its line. A second collision is run against a full table: a response frees a slot while an instruction is held. The bench checks that `in_ready` rises exactly one cycle after the retirement.

// File: rtl/coal_pkg.sv
// Shared types for the line coalescing table.
// Assumes: nothing beyond IEEE 1800-2017.
package coal_pkg;
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;
endpackage

// File: rtl/coal_first_one.sv
// Finds the lowest set bit of a request vector.
// Assumes: N >= 1; idx is don't-care when found is low (drives 0).
module coal_first_one #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/coal_line_merge.sv
// Picks the lowest pending lane as leader and marks every pending lane
// that lies in the same cache line as the leader.
// Assumes: addr is flat, lane l at [l*ADDR_W +: ADDR_W]; OFF < ADDR_W.
module coal_line_merge #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 16,
    parameter int OFF    = 4,
    parameter int LINE_W = ADDR_W - OFF
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES-1:0]        pend,
    output logic                    any,
    output logic [LINE_W-1:0]       line,
    output logic [LANES-1:0]        merge
);
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LINE_W-1:0] lane_line [LANES];
    logic [LIDX_W-1:0] lead;

    // strip the byte offset of every lane
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_line[l] = addr[l*ADDR_W+OFF +: LINE_W];
        end
    end

    coal_first_one #(.N(LANES), .IDX_W(LIDX_W)) u_lead (
        .req   (pend),
        .found (any),
        .idx   (lead)
    );

    // gather pending lanes that share the leader's line
    always_comb begin
        line = lane_line[lead];
        for (int l = 0; l < LANES; l++) begin
            merge[l] = pend[l] && (lane_line[l] == line);
        end
    end
endmodule

// File: rtl/coal_table.sv
// Coalescing table: merges same-line lanes of one instruction into an
// entry, keeps same-line entries in age order, issues head entries and
// retires them on line-addressed responses.
// Assumes: MAX_OUT <= DEPTH; the input holds its instruction stable until
// in_ready; responses only name lines that were issued (others ignored).
module coal_table
    import coal_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    parameter int DEPTH      = 4,
    parameter int MAX_OUT    = 4,
    parameter int SEQ_W      = 8,
    parameter int TIME_W     = 16,
    localparam int OFF       = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF,
    localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SEQ_W-1:0]        in_seq,
    input  logic                    in_write,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    output logic                    in_ready,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [LINE_W-1:0]       mem_req_line,
    output logic                    mem_req_write,
    input  logic                    mem_rsp_valid,
    input  logic [LINE_W-1:0]       mem_rsp_line,
    output logic                    cpl_valid,
    output logic [SEQ_W-1:0]        cpl_seq,
    output logic [LANES-1:0]        cpl_mask,
    output logic                    cpl_write,
    output logic [TIME_W-1:0]       cpl_latency,
    output logic [CNT_W-1:0]        outstanding
);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WAIT_W = $clog2(DEPTH + 1);

    // entry storage
    logic [DEPTH-1:0]  ent_vld;
    logic [DEPTH-1:0]  ent_iss;
    logic [LINE_W-1:0] ent_line [DEPTH];
    logic [SEQ_W-1:0]  ent_seq  [DEPTH];
    acc_e              ent_kind [DEPTH];
    logic [LANES-1:0]  ent_mask [DEPTH];
    logic [WAIT_W-1:0] ent_wait [DEPTH];
    logic [TIME_W-1:0] ent_t0   [DEPTH];

    logic [TIME_W-1:0] now;
    logic [CNT_W-1:0]  cnt;
    logic [LANES-1:0]  taken;

    logic [LANES-1:0]  pend;
    logic              grp_any;
    logic [LINE_W-1:0] grp_line;
    logic [LANES-1:0]  grp_mask;
    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    logic              alloc;
    logic              last_grp;
    logic [DEPTH-1:0]  elig;
    logic              iss_found;
    logic [IDX_W-1:0]  iss_idx;
    logic              fire;
    logic [DEPTH-1:0]  hit;
    logic              retire;
    logic [IDX_W-1:0]  ret_idx;
    logic [WAIT_W-1:0] wait_new;

    // lanes of the current instruction not yet placed in an entry
    assign pend = in_valid ? (in_mask & ~taken) : '0;

    coal_line_merge #(
        .LANES(LANES), .ADDR_W(ADDR_W), .OFF(OFF), .LINE_W(LINE_W)
    ) u_merge (
        .addr  (in_addr),
        .pend  (pend),
        .any   (grp_any),
        .line  (grp_line),
        .merge (grp_mask)
    );

    coal_first_one #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
        .req   (~ent_vld),
        .found (free_found),
        .idx   (free_idx)
    );

    // allocation gate: a group exists, room under the limit, a free slot
    assign alloc    = grp_any && (cnt < CNT_W'(MAX_OUT)) && free_found;
    assign last_grp = ((pend & ~grp_mask) == '0);
    assign in_ready = in_valid && ((pend == '0) || (alloc && last_grp));

    // head entries not yet sent are eligible for issue
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = ent_vld[i] && !ent_iss[i] && (ent_wait[i] == '0);
        end
    end

    coal_first_one #(.N(DEPTH), .IDX_W(IDX_W)) u_issue (
        .req   (elig),
        .found (iss_found),
        .idx   (iss_idx)
    );

    assign mem_req_valid = iss_found;
    assign mem_req_line  = ent_line[iss_idx];
    assign mem_req_write = (ent_kind[iss_idx] == ACC_WRITE);
    assign fire          = mem_req_valid && mem_req_ready;

    // a response matches only an issued head entry of its line
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = mem_rsp_valid && ent_vld[i] && ent_iss[i] &&
                     (ent_wait[i] == '0) && (ent_line[i] == mem_rsp_line);
        end
    end

    coal_first_one #(.N(DEPTH), .IDX_W(IDX_W)) u_ret (
        .req   (hit),
        .found (retire),
        .idx   (ret_idx)
    );

    // age position of a new entry: same-line entries that survive this edge
    always_comb begin
        wait_new = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_vld[i] && (ent_line[i] == grp_line) &&
                !(retire && (ret_idx == IDX_W'(i)))) begin
                wait_new = wait_new + 1'b1;
            end
        end
    end

    // free-running cycle stamp
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // live entry counter
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (alloc && !retire)  cnt <= cnt + 1'b1;
        else if (!alloc && retire)  cnt <= cnt - 1'b1;
    end
    assign outstanding = cnt;

    // record lanes already placed for a partly absorbed instruction
    always_ff @(posedge clk) begin
        if (!rst_n || in_ready) taken <= '0;
        else if (alloc)         taken <= taken | grp_mask;
    end

    // entry state: allocate, issue, retire and age shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_iss <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_line[i] <= '0;
                ent_seq[i]  <= '0;
                ent_kind[i] <= ACC_READ;
                ent_mask[i] <= '0;
                ent_wait[i] <= '0;
                ent_t0[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire && (ret_idx == IDX_W'(i))) begin
                    ent_vld[i] <= 1'b0;
                    ent_iss[i] <= 1'b0;
                end else if (retire && ent_vld[i] && (ent_wait[i] != '0) &&
                             (ent_line[i] == ent_line[ret_idx])) begin
                    ent_wait[i] <= ent_wait[i] - 1'b1;
                end
                if (fire && (iss_idx == IDX_W'(i))) begin
                    ent_iss[i] <= 1'b1;
                    ent_t0[i]  <= now;
                end
                if (alloc && (free_idx == IDX_W'(i))) begin
                    ent_vld[i]  <= 1'b1;
                    ent_iss[i]  <= 1'b0;
                    ent_line[i] <= grp_line;
                    ent_seq[i]  <= in_seq;
                    ent_kind[i] <= acc_e'(in_write);
                    ent_mask[i] <= grp_mask;
                    ent_wait[i] <= wait_new;
                end
            end
        end
    end

    // completion report, one cycle after the retiring response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid   <= 1'b0;
            cpl_seq     <= '0;
            cpl_mask    <= '0;
            cpl_write   <= 1'b0;
            cpl_latency <= '0;
        end else begin
            cpl_valid   <= retire;
            cpl_seq     <= ent_seq[ret_idx];
            cpl_mask    <= ent_mask[ret_idx];
            cpl_write   <= (ent_kind[ret_idx] == ACC_WRITE);
            cpl_latency <= now - ent_t0[ret_idx];
        end
    end

    // ---------------- assertions ----------------
    assert_cnt_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_OUT));

    assert_full_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (pend != '0) && (cnt == CNT_W'(MAX_OUT))) |-> !in_ready);

    assert_cnt_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_vld) == int'(cnt));

    assert_cpl_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> ($past(mem_rsp_valid) && (cpl_mask != '0)));

    assert_group_in_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (((grp_mask & ~pend) == '0) && (grp_mask != '0)));

    generate
        for (genvar a = 0; a < DEPTH; a++) begin : g_pa
            for (genvar b = a + 1; b < DEPTH; b++) begin : g_pb
                assert_unique_age_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (ent_vld[a] && ent_vld[b] && (ent_line[a] == ent_line[b]))
                        |-> (ent_wait[a] != ent_wait[b]));
            end
        end
    endgenerate
endmodule

// File: tb/test_coal_table.sv
module test_coal_table;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int ADDR_W = 16;
    localparam int LINE_W = 12;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [63:0] addrs;
        logic [3:0]  mask;
        logic [3:0]  ng;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{{16'h010C, 16'h0108, 16'h0104, 16'h0100}, 4'hF, 4'd1},
        '{{16'h0204, 16'h0104, 16'h0200, 16'h0100}, 4'hF, 4'd2},
        '{{16'h0330, 16'h0320, 16'h0310, 16'h0300}, 4'hF, 4'd4},
        '{{16'h0600, 16'h040F, 16'h0500, 16'h0400}, 4'hD, 4'd2},
        '{{16'h0000, 16'h0000, 16'h0000, 16'h0000}, 4'h0, 4'd0},
        '{{16'h07FF, 16'h0800, 16'h07F8, 16'h07F0}, 4'hF, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_seq = '0;
    logic in_write = 1'b0;
    logic [LANES-1:0] in_mask = '0;
    logic [LANES*ADDR_W-1:0] in_addr = '0;
    logic in_ready;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [LINE_W-1:0] mem_req_line;
    logic mem_req_write;
    logic mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_line = '0;
    logic cpl_valid;
    logic [7:0] cpl_seq;
    logic [LANES-1:0] cpl_mask;
    logic cpl_write;
    logic [15:0] cpl_latency;
    logic [2:0] outstanding;

    int total = 0;
    int bad = 0;
    int g_num;
    logic [3:0] g_mask [4];
    logic [LINE_W-1:0] g_line [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    coal_table i_coal_table (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_seq(in_seq), .in_write(in_write),
        .in_mask(in_mask), .in_addr(in_addr), .in_ready(in_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_req_write(mem_req_write),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
        .cpl_valid(cpl_valid), .cpl_seq(cpl_seq), .cpl_mask(cpl_mask),
        .cpl_write(cpl_write), .cpl_latency(cpl_latency),
        .outstanding(outstanding)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // bench model of line grouping, lowest pending lane leads
    task automatic model_groups(input logic [63:0] a, input logic [3:0] m);
        logic [3:0] p;
        p = m;
        g_num = 0;
        while (p != 0) begin
            int lead;
            logic [LINE_W-1:0] ln;
            logic [3:0] gm;
            lead = 0;
            while (!p[lead]) lead++;
            ln = LINE_W'(a[lead*16 +: 16] >> 4);
            gm = '0;
            for (int l = 0; l < 4; l++)
                if (p[l] && (LINE_W'(a[l*16 +: 16] >> 4) == ln)) gm[l] = 1'b1;
            g_mask[g_num] = gm;
            g_line[g_num] = ln;
            g_num++;
            p = p & ~gm;
        end
    endtask

    // present an instruction until accepted; returns cycles waited
    task automatic send(input logic [7:0] seq, input logic wr,
                        input logic [3:0] m, input logic [63:0] a,
                        output int waited);
        @(negedge clk);
        in_valid = 1'b1; in_seq = seq; in_write = wr;
        in_mask = m; in_addr = a;
        waited = 0;
        #1;
        while (!in_ready && waited < 50) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic issue_n(input int n);
        @(negedge clk);
        mem_req_ready = 1'b1;
        repeat (n) @(negedge clk);
        mem_req_ready = 1'b0;
    endtask

    // respond to a line; leaves time at the negedge after the response edge
    task automatic respond(input logic [LINE_W-1:0] ln);
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_line = ln;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "outstanding", outstanding, 0);
        chk("R1", "mem_req_valid", mem_req_valid, 0);
        chk("R1", "cpl_valid", cpl_valid, 0);

        // table walk: grouping, absorb time, issue, completion masks
        for (int v = 0; v < NVEC; v++) begin
            model_groups(VECS[v].addrs, VECS[v].mask);
            chk("R3", "model group count", g_num, VECS[v].ng);
            send(8'(16 + v), v[0], VECS[v].mask, VECS[v].addrs, w);
            chk("R3", "cycles to absorb", w, (g_num == 0) ? 0 : g_num - 1);
            #1;
            chk("R2", "entries created", outstanding, g_num);
            if (g_num > 0) begin
                chk("R7", "req valid", mem_req_valid, 1);
                chk("R2", "first req line", mem_req_line, g_line[0]);
                chk("R7", "req kind", mem_req_write, v[0]);
                issue_n(g_num);
                #1;
                chk("R7", "all issued", mem_req_valid, 0);
                for (int g = 0; g < g_num; g++) begin
                    respond(g_line[g]);
                    chk("R8", "cpl valid", cpl_valid, 1);
                    chk("R8", "cpl seq", cpl_seq, 16 + v);
                    chk("R8", "cpl mask", cpl_mask, g_mask[g]);
                    chk("R8", "cpl kind", cpl_write, v[0]);
                end
                chk("R11", "drained", outstanding, 0);
            end
        end

        // R4 / R6: two instructions, same line, kept apart and ordered
        send(8'd1, 1'b0, 4'h1, 64'h0900, w);
        send(8'd2, 1'b0, 4'h1, 64'h0900, w);
        #1;
        chk("R4", "two entries same line", outstanding, 2);
        chk("R6", "older offered line", mem_req_line, 12'h090);
        issue_n(1);
        #1;
        chk("R6", "younger held back", mem_req_valid, 0);
        respond(12'h090);
        chk("R6", "older completes first", cpl_seq, 1);
        chk("R6", "younger now offered", mem_req_valid, 1);
        issue_n(1);
        respond(12'h090);
        chk("R6", "younger completes", cpl_seq, 2);
        chk("R4", "drained", outstanding, 0);

        // R9 / R10: ignored responses and latency
        send(8'd3, 1'b1, 4'h1, 64'h0A00, w);
        respond(12'h0A0);
        chk("R9", "unissued line ignored", cpl_valid, 0);
        chk("R9", "count kept", outstanding, 1);
        @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_line = 12'h0B0;
        @(negedge clk);
        mem_rsp_line = 12'h0A0;
        #1;
        chk("R9", "unknown line ignored", cpl_valid, 0);
        chk("R9", "count kept after unknown", outstanding, 1);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        chk("R8", "issued entry completes", cpl_valid, 1);
        chk("R10", "latency", cpl_latency, 2);
        chk("R8", "write kind", cpl_write, 1);

        // R11 / R6: retire and allocate the same line at one edge
        send(8'd4, 1'b0, 4'h1, 64'h0C00, w);
        issue_n(1);
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_line = 12'h0C0;
        in_valid = 1'b1; in_seq = 8'd5; in_mask = 4'h1; in_addr = 64'h0C04;
        #1;
        chk("R11", "accepted during retire", in_ready, 1);
        @(negedge clk);
        mem_rsp_valid = 1'b0; in_valid = 1'b0;
        #1;
        chk("R11", "old entry completes", cpl_seq, 4);
        chk("R11", "count unchanged", outstanding, 1);
        chk("R6", "new entry is head", mem_req_valid, 1);
        chk("R6", "new entry line", mem_req_line, 12'h0C0);
        issue_n(1);
        respond(12'h0C0);
        chk("R11", "second completes", cpl_seq, 5);

        // R5: full table holds the next instruction until a retirement
        send(8'd6, 1'b0, 4'hF, VECS[2].addrs, w);
        #1;
        chk("R5", "table full", outstanding, 4);
        @(negedge clk);
        in_valid = 1'b1; in_seq = 8'd7; in_mask = 4'h1; in_addr = 64'h0D00;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R5", "held while full", in_ready, 0);
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        repeat (4) @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_line = 12'h030;
        #1;
        chk("R5", "held in retire cycle", in_ready, 0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        chk("R5", "accepted after room", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R5", "full again", outstanding, 4);
        issue_n(1);
        respond(12'h031);
        respond(12'h032);
        respond(12'h033);
        respond(12'h0D0);
        chk("R8", "last completion seq", cpl_seq, 7);
        chk("R11", "final drain", outstanding, 0);

        finish_run();
    end
endmodule